// File: doc/BRIEF.md
# Exception Target Level Resolver

This block sits beside the privilege control of a processor core and decides where an exception goes. For every entry request it picks the privilege level that will handle the exception. It also picks whether that level runs with the wide (64-bit) or narrow (32-bit) register view. It raises an illegal flag when the configuration forbids the move. The decision depends on the current level, the current security world, the exception class, two sets of per-class upward routing bits (one toward the monitor level 3, one toward the hypervisor level 2), flags saying whether levels 2 and 3 are built at all, and a per-level width configuration.

The same block checks exception returns. A return names a destination level, a destination width and, when it leaves level 3, the destination security world. An illegal return leaves the state as it was. The current level, width and world sit in three small registers. These registers change only when an entry or return strobe is accepted. Everything else is combinational, so the resolved target is visible in the same cycle as the strobe.

Top module: `exc_level_router`

## Requirements
- R1: Synchronous active-low reset loads the current level with the highest built level (3 if `has_l3`, else 2 if `has_l2`, else 1). It sets the secure world equal to `has_l3` and the width to `lvl_wide[level]`.
- R2: An entry never targets level 0. A synchronous-class entry (`exc_cls` = 0) targets the current level, raised to 1 when the current level is 0.
- R3: Class codes for `exc_cls` are 1 = IRQ, 2 = FIQ and 3 = system error, and the bit for each class in `route_l3` and `route_l2` is at position code-1. A set routing bit lifts the target to that level, and level 3 wins when both bits are set. The target is the higher of the routed level and the level from R2.
- R4: A routing bit toward a level that is not built is ignored, and an entry never targets an absent level.
- R5: In the secure world, bits in `route_l2` are ignored. A return whose resulting world is secure and whose destination is level 2 is illegal.
- R6: On entry, `tgt_wide` equals `lvl_wide[tgt_lvl]`. An entry from a wide current state to a target configured narrow is illegal.
- R7: A return to a level above the current one, or to a level that is not built, is illegal. `tgt_lvl` then shows the current level and the state is held.
- R8: A return requesting the wide state while the current state is narrow is illegal. Narrow-to-narrow, wide-to-wide and wide-to-narrow returns are legal.
- R9: The security world changes only on a legal return from level 3, where it takes `ret_secure`.
- R10: The state registers update only on a strobe with the illegal flag clear. When both strobes are high, the entry is served and the return is ignored.
- R11: With no strobe, `tgt_lvl` equals `cur_lvl`, `tgt_wide` equals `cur_wide`, and `illegal` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| has_l2 | input | 1 | Level 2 is built |
| has_l3 | input | 1 | Level 3 is built |
| lvl_wide | input | 4 | Per-level width configuration, bit n = level n is wide |
| entry_req | input | 1 | Exception entry strobe |
| exc_cls | input | 2 | Exception class: 0 sync, 1 IRQ, 2 FIQ, 3 system error |
| route_l3 | input | 3 | Per-async-class routing to level 3 |
| route_l2 | input | 3 | Per-async-class routing to level 2 |
| ret_req | input | 1 | Exception return strobe |
| ret_lvl | input | 2 | Requested return level |
| ret_wide | input | 1 | Requested return width, 1 = wide |
| ret_secure | input | 1 | World after a return from level 3 |
| tgt_lvl | output | 2 | Resolved target level |
| tgt_wide | output | 1 | Resolved target width |
| illegal | output | 1 | Requested move is not allowed |
| cur_lvl | output | 2 | Current level |
| cur_wide | output | 1 | Current width |
| cur_secure | output | 1 | Current world is secure |

## Verification
The in-RTL properties watch every cycle for these rules:
- an entry never lands on level 0 or below the current level;
- level 2 is never a target in the secure world;
- absent levels are never picked;
- a legal entry never narrows a wide state;
- a return never widens a narrow state;
- the state registers stay still without an accepted strobe.

Other behaviour can only be shown by the bench's scenarios: which of the routing bits wins, the class-to-bit mapping, the reset level for each build configuration, and entry taking precedence over a simultaneous return. The bench walks a chain of entries and returns through every level and both worlds to show them.

// File: rtl/exc_route_pkg.sv
package exc_route_pkg;

  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 4;
  localparam int ASYNC_N = 3;

  typedef enum logic [1:0] {
    CLS_SYNC = 2'd0,
    CLS_IRQ  = 2'd1,
    CLS_FIQ  = 2'd2,
    CLS_SERR = 2'd3
  } exc_cls_e;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic             wide;
    logic             secure;
  } lvl_state_t;

  // one-hot routing-bit select for an asynchronous class
  function automatic logic [ASYNC_N-1:0] cls_mask(input exc_cls_e c);
    case (c)
      CLS_IRQ:  return 3'b001;
      CLS_FIQ:  return 3'b010;
      CLS_SERR: return 3'b100;
      default:  return 3'b000;
    endcase
  endfunction

  function automatic logic [LVL_W-1:0] lvl_max(input logic [LVL_W-1:0] a,
                                               input logic [LVL_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic lvl_present(input logic [LVL_W-1:0] l,
                                       input logic has2, input logic has3);
    case (l)
      2'd2:    return has2;
      2'd3:    return has3;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [LVL_W-1:0] top_lvl(input logic has2, input logic has3);
    if (has3)      return 2'd3;
    else if (has2) return 2'd2;
    else           return 2'd1;
  endfunction

endpackage

// File: rtl/exc_entry_sel.sv
module exc_entry_sel
  import exc_route_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  lvl_state_t         cur,
  input  logic [1:0]         cls,
  input  logic [ASYNC_N-1:0] route_l3,
  input  logic [ASYNC_N-1:0] route_l2,
  input  logic               has_l2,
  input  logic               has_l3,
  input  logic [NUM_LVL-1:0] lvl_wide,
  output logic [LVL_W-1:0]   e_lvl,
  output logic               e_wide,
  output logic               e_bad
);

  logic [ASYNC_N-1:0] sel;
  logic [LVL_W-1:0]   base_lvl;
  logic [LVL_W-1:0]   routed_lvl;
  logic               up3;
  logic               up2;

  always_comb begin
    sel        = cls_mask(exc_cls_e'(cls));
    base_lvl   = (cur.lvl == 2'd0) ? 2'd1 : cur.lvl;
    up3        = |(sel & route_l3) && has_l3;
    up2        = |(sel & route_l2) && has_l2 && !cur.secure;
    routed_lvl = up3 ? 2'd3 : (up2 ? 2'd2 : base_lvl);
    e_lvl      = lvl_max(base_lvl, routed_lvl);
    e_wide     = lvl_wide[e_lvl];
    e_bad      = cur.wide && !e_wide;
  end

  // R2: entry goes up or stays, never to level 0
  a_r2_never_down: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (e_lvl != 2'd0) && (e_lvl >= cur.lvl));

  // R4: absent levels never chosen
  a_r4_present_only: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ((e_lvl != 2'd3) || has_l3) && ((e_lvl != 2'd2) || has_l2));

  // R5: no level 2 target while secure
  a_r5_secure_no_l2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cur.secure && cur.lvl != 2'd2) |-> (e_lvl != 2'd2));

  // R6: legal entry never narrows a wide state
  a_r6_no_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !e_bad && cur.wide) |-> e_wide);

endmodule

// File: rtl/exc_return_chk.sv
module exc_return_chk
  import exc_route_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  lvl_state_t       cur,
  input  logic [LVL_W-1:0] ret_lvl,
  input  logic             ret_wide,
  input  logic             ret_secure,
  input  logic             has_l2,
  input  logic             has_l3,
  output lvl_state_t       r_nxt,
  output logic             r_bad
);

  logic new_sec;
  logic go_above;
  logic go_absent;
  logic sec_l2;
  logic widen;

  always_comb begin
    new_sec   = (cur.lvl == 2'd3) ? ret_secure : cur.secure;
    go_above  = ret_lvl > cur.lvl;
    go_absent = !lvl_present(ret_lvl, has_l2, has_l3);
    sec_l2    = new_sec && (ret_lvl == 2'd2);
    widen     = ret_wide && !cur.wide;
    r_bad     = go_above || go_absent || sec_l2 || widen;
    if (r_bad) begin
      r_nxt = cur;
    end else begin
      r_nxt.lvl    = ret_lvl;
      r_nxt.wide   = ret_wide;
      r_nxt.secure = new_sec;
    end
  end

  // R8: accepted return never widens a narrow state
  a_r8_no_widen: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !r_bad && !cur.wide) |-> !r_nxt.wide);

  // R7: accepted return never goes up
  a_r7_not_above: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !r_bad) |-> (r_nxt.lvl <= cur.lvl));

endmodule

// File: rtl/exc_state_reg.sv
module exc_state_reg
  import exc_route_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               has_l2,
  input  logic               has_l3,
  input  logic [NUM_LVL-1:0] lvl_wide,
  input  logic               load,
  input  lvl_state_t         nxt,
  output lvl_state_t         cur
);

  logic [LVL_W-1:0] rst_lvl;
  assign rst_lvl = top_lvl(has_l2, has_l3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur.lvl    <= rst_lvl;
      cur.wide   <= lvl_wide[rst_lvl];
      cur.secure <= has_l3;
    end else if (load) begin
      cur <= nxt;
    end
  end

  // R10: state holds without a load
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cur));

endmodule

// File: rtl/exc_level_router.sv
module exc_level_router
  import exc_route_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       has_l2,
  input  logic       has_l3,
  input  logic [3:0] lvl_wide,
  input  logic       entry_req,
  input  logic [1:0] exc_cls,
  input  logic [2:0] route_l3,
  input  logic [2:0] route_l2,
  input  logic       ret_req,
  input  logic [1:0] ret_lvl,
  input  logic       ret_wide,
  input  logic       ret_secure,
  output logic [1:0] tgt_lvl,
  output logic       tgt_wide,
  output logic       illegal,
  output logic [1:0] cur_lvl,
  output logic       cur_wide,
  output logic       cur_secure
);

  lvl_state_t       cur;
  lvl_state_t       r_nxt;
  lvl_state_t       nxt;
  logic [LVL_W-1:0] e_lvl;
  logic             e_wide;
  logic             e_bad;
  logic             r_bad;
  logic             ret_only;
  logic             load;

  exc_entry_sel u_entry (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (entry_req),
    .cur      (cur),
    .cls      (exc_cls),
    .route_l3 (route_l3),
    .route_l2 (route_l2),
    .has_l2   (has_l2),
    .has_l3   (has_l3),
    .lvl_wide (lvl_wide),
    .e_lvl    (e_lvl),
    .e_wide   (e_wide),
    .e_bad    (e_bad)
  );

  exc_return_chk u_ret (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (ret_only),
    .cur        (cur),
    .ret_lvl    (ret_lvl),
    .ret_wide   (ret_wide),
    .ret_secure (ret_secure),
    .has_l2     (has_l2),
    .has_l3     (has_l3),
    .r_nxt      (r_nxt),
    .r_bad      (r_bad)
  );

  assign ret_only = ret_req && !entry_req;

  always_comb begin
    nxt      = cur;
    tgt_lvl  = cur.lvl;
    tgt_wide = cur.wide;
    illegal  = 1'b0;
    load     = 1'b0;
    if (entry_req) begin
      nxt.lvl  = e_lvl;
      nxt.wide = e_wide;
      tgt_lvl  = e_lvl;
      tgt_wide = e_wide;
      illegal  = e_bad;
      load     = !e_bad;
    end else if (ret_req) begin
      nxt      = r_nxt;
      tgt_lvl  = r_nxt.lvl;
      tgt_wide = r_nxt.wide;
      illegal  = r_bad;
      load     = !r_bad;
    end
  end

  exc_state_reg u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .has_l2   (has_l2),
    .has_l3   (has_l3),
    .lvl_wide (lvl_wide),
    .load     (load),
    .nxt      (nxt),
    .cur      (cur)
  );

  assign cur_lvl    = cur.lvl;
  assign cur_wide   = cur.wide;
  assign cur_secure = cur.secure;

  // R9: world changes only after a return from level 3
  a_r9_world_change: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_secure != $past(cur_secure)) |-> ($past(ret_only) && $past(cur_lvl) == 2'd3));

  // R7: illegal return leaves the level as it was
  a_r7_bad_ret_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_only && r_bad) |=> $stable(cur_lvl));

  // R11: idle output mirrors state
  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!entry_req && !ret_req) |-> (!illegal && tgt_lvl == cur_lvl && tgt_wide == cur_wide));

endmodule

// File: tb/exc_level_router_bench.sv
module exc_level_router_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       has_l2, has_l3;
  logic [3:0] lvl_wide;
  logic       entry_req;
  logic [1:0] exc_cls;
  logic [2:0] route_l3, route_l2;
  logic       ret_req;
  logic [1:0] ret_lvl;
  logic       ret_wide, ret_secure;
  logic [1:0] tgt_lvl;
  logic       tgt_wide, illegal;
  logic [1:0] cur_lvl;
  logic       cur_wide, cur_secure;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  exc_level_router u_exc_level_router (
    .clk(clk), .rst_n(rst_n), .has_l2(has_l2), .has_l3(has_l3),
    .lvl_wide(lvl_wide), .entry_req(entry_req), .exc_cls(exc_cls),
    .route_l3(route_l3), .route_l2(route_l2), .ret_req(ret_req),
    .ret_lvl(ret_lvl), .ret_wide(ret_wide), .ret_secure(ret_secure),
    .tgt_lvl(tgt_lvl), .tgt_wide(tgt_wide), .illegal(illegal),
    .cur_lvl(cur_lvl), .cur_wide(cur_wide), .cur_secure(cur_secure)
  );

  // {op(1 entry,2 return), cls, rt3, rt2, rlvl, rwide, rsec, lw, exp_lvl, exp_wide, exp_bad, exp_cur}
  localparam int NV = 21;
  localparam logic [23:0] VEC [NV] = '{
    {2'd2,2'd0,3'd0,3'd0,2'd1,1'b1,1'b0,4'hF, 2'd1,1'b1,1'b0,2'd1}, // R7 ret 3->1
    {2'd2,2'd0,3'd0,3'd0,2'd0,1'b0,1'b0,4'hF, 2'd0,1'b0,1'b0,2'd0}, // R8 wide->narrow
    {2'd1,2'd0,3'd0,3'd0,2'd0,1'b0,1'b0,4'hF, 2'd1,1'b1,1'b0,2'd1}, // R2 sync from 0
    {2'd2,2'd0,3'd0,3'd0,2'd2,1'b1,1'b0,4'hF, 2'd1,1'b1,1'b1,2'd1}, // R7 above
    {2'd2,2'd0,3'd0,3'd0,2'd0,1'b1,1'b0,4'hF, 2'd0,1'b1,1'b0,2'd0}, // R8 wide->wide
    {2'd1,2'd1,3'd0,3'd1,2'd0,1'b0,1'b0,4'hF, 2'd2,1'b1,1'b0,2'd2}, // R3 irq to 2
    {2'd1,2'd2,3'd2,3'd2,2'd0,1'b0,1'b0,4'hF, 2'd3,1'b1,1'b0,2'd3}, // R3 l3 wins
    {2'd2,2'd0,3'd0,3'd0,2'd2,1'b1,1'b1,4'hF, 2'd3,1'b1,1'b1,2'd3}, // R5 secure l2
    {2'd2,2'd0,3'd0,3'd0,2'd2,1'b0,1'b0,4'hB, 2'd2,1'b0,1'b0,2'd2}, // R8 ret narrow
    {2'd2,2'd0,3'd0,3'd0,2'd1,1'b1,1'b0,4'hF, 2'd2,1'b0,1'b1,2'd2}, // R8 widen bad
    {2'd1,2'd3,3'd4,3'd0,2'd0,1'b0,1'b0,4'hF, 2'd3,1'b1,1'b0,2'd3}, // R3 serr, R6
    {2'd2,2'd0,3'd0,3'd0,2'd1,1'b0,1'b0,4'hF, 2'd1,1'b0,1'b0,2'd1}, // R9 to ns
    {2'd1,2'd0,3'd0,3'd0,2'd0,1'b0,1'b0,4'hD, 2'd1,1'b0,1'b0,2'd1}, // R2 sync same
    {2'd1,2'd1,3'd0,3'd0,2'd0,1'b0,1'b0,4'hD, 2'd1,1'b0,1'b0,2'd1}, // R3 no route
    {2'd2,2'd0,3'd0,3'd0,2'd0,1'b0,1'b0,4'hF, 2'd0,1'b0,1'b0,2'd0}, // R7 to 0
    {2'd1,2'd0,3'd0,3'd0,2'd0,1'b0,1'b0,4'hF, 2'd1,1'b1,1'b0,2'd1}, // R6 narrow->wide
    {2'd1,2'd0,3'd0,3'd0,2'd0,1'b0,1'b0,4'hD, 2'd1,1'b0,1'b1,2'd1}, // R6 wide->narrow bad
    {2'd1,2'd2,3'd2,3'd0,2'd0,1'b0,1'b0,4'hF, 2'd3,1'b1,1'b0,2'd3}, // R3 fiq to 3
    {2'd2,2'd0,3'd0,3'd0,2'd1,1'b1,1'b1,4'hF, 2'd1,1'b1,1'b0,2'd1}, // R9 to secure
    {2'd1,2'd1,3'd0,3'd1,2'd0,1'b0,1'b0,4'hF, 2'd1,1'b1,1'b0,2'd1}, // R5 l2 route ignored
    {2'd2,2'd0,3'd0,3'd0,2'd3,1'b1,1'b1,4'hF, 2'd1,1'b1,1'b1,2'd1}  // R7 above to 3
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_in();
    entry_req = 0; ret_req = 0; exc_cls = 0; route_l3 = 0; route_l2 = 0;
    ret_lvl = 0; ret_wide = 0; ret_secure = 0;
  endtask

  task automatic do_reset(input logic h2, input logic h3, input logic [3:0] lw);
    @(negedge clk);
    idle_in();
    has_l2 = h2; has_l3 = h3; lvl_wide = lw; rst_n = 0;
    @(posedge clk); @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      finish_run();
    end
  end

  initial begin
    idle_in();
    has_l2 = 1; has_l3 = 1; lvl_wide = 4'hF; rst_n = 0;

    // R1 reset, R11 idle outputs
    do_reset(1, 1, 4'hF);
    chk("R1 lvl", cur_lvl, 3);
    chk("R1 sec", cur_secure, 1);
    chk("R1 wide", cur_wide, 1);
    chk("R11 tgt", tgt_lvl, 3);
    chk("R11 ill", illegal, 0);

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      v = VEC[i];
      @(negedge clk);
      entry_req  = (v[23:22] == 2'd1);
      ret_req    = (v[23:22] == 2'd2);
      exc_cls    = v[21:20];
      route_l3   = v[19:17];
      route_l2   = v[16:14];
      ret_lvl    = v[13:12];
      ret_wide   = v[11];
      ret_secure = v[10];
      lvl_wide   = v[9:6];
      #1;
      chk($sformatf("vec%0d tgt_lvl", i), tgt_lvl, v[5:4]);
      chk($sformatf("vec%0d tgt_wide", i), tgt_wide, v[3]);
      chk($sformatf("vec%0d illegal", i), illegal, v[2]);
      @(posedge clk);
      #1;
      idle_in();
      lvl_wide = 4'hF;
      chk($sformatf("vec%0d cur_lvl", i), cur_lvl, v[1:0]);
      if (i == 11) chk("R9 ns after ret", cur_secure, 0);
      if (i == 18) chk("R9 secure after ret", cur_secure, 1);
    end

    // R10: both strobes, entry served, return ignored
    do_reset(1, 1, 4'hF);
    @(negedge clk);
    entry_req = 1; ret_req = 1; exc_cls = 0; ret_lvl = 1; ret_secure = 0;
    #1;
    chk("R10 both tgt", tgt_lvl, 3);
    @(posedge clk); #1; idle_in();
    chk("R10 both cur", cur_lvl, 3);
    chk("R10 both sec", cur_secure, 1);

    // R1/R4: no level 3 built
    do_reset(1, 0, 4'hF);
    chk("R1 no-l3 lvl", cur_lvl, 2);
    chk("R1 no-l3 sec", cur_secure, 0);
    @(negedge clk);
    entry_req = 1; exc_cls = 1; route_l3 = 3'b001;
    #1;
    chk("R4 l3 route ignored", tgt_lvl, 2);
    @(posedge clk); #1; idle_in();
    @(negedge clk);
    ret_req = 1; ret_lvl = 3; ret_wide = 1;
    #1;
    chk("R7 absent ret", illegal, 1);
    @(posedge clk); #1; idle_in();
    chk("R7 absent hold", cur_lvl, 2);

    // R1/R4: neither optional level built
    do_reset(0, 0, 4'hF);
    chk("R1 base lvl", cur_lvl, 1);
    @(negedge clk);
    entry_req = 1; exc_cls = 1; route_l2 = 3'b001;
    #1;
    chk("R4 l2 route ignored", tgt_lvl, 1);
    @(posedge clk); #1; idle_in();

    // R1: narrow top level at reset
    do_reset(1, 1, 4'h7);
    chk("R1 narrow reset", cur_wide, 0);

    finish_run();
  end

endmodule